// File: doc/BRIEF.md
# SD Command Issue Engine

This block is the command half of a host-side SD/MMC controller. Software loads a 32-bit argument, then writes a control word that holds a 6-bit command index and a start flag. Two more flags in that word ask for no response, a short response or a long response. The engine builds a 48-bit command frame with its CRC7 and shifts it out on the CMD line. When a response is requested, it waits a bounded time for the card's start bit and captures the reply into four 32-bit response registers.

Progress and errors are reported through sticky status flags that software clears by writing ones. The SD bus clock comes from a programmable prescaler. The block drives the CMD line on falling SD clock edges and samples it on rising ones. It does not check the CRC of the response, and it does not handle the data lines.

Top module: `sd_cmd_engine`

Register map (word address on `wr_addr`/`rd_addr`): 0 control, 1 argument, 2 status, 3 prescaler, 4 to 7 response words 0 to 3.

## Requirements
- R1: A control write (address 0) with bit 8 set while idle starts a command. Bits [5:0] give the index, bit 6 is a stored host flag, bit 9 asks for a response and bit 10 makes that response long. Reading address 0 returns these fields, with bit 8 reading 0.
- R2: The frame is 48 bits sent MSB first: a 0 start bit, a 1, the index, the argument, CRC7 (polynomial x^7+x^3+1, computed over the first 40 bits) and a 1 end bit. Each bit changes only on a falling edge of `sd_clk`, and `cmd_oe` is low whenever the engine is idle.
- R3: The argument register (address 1) is sent as frame bits [39:8].
- R4: `sd_clk` has a period of 2*(P+1) `clk` cycles, where P is the prescaler register (address 3).
- R5: Status bit 11 (sent) sets when the last frame bit has been driven. Without a response request the command then ends. With one, it ends when bit 9 (response finished) sets.
- R6: After the frame, the engine samples CMD on 64 rising SD clock edges. A start bit seen on the 64th sample is still accepted. With no start bit, status bit 10 (timeout) sets, bit 9 stays clear, the command ends and the response registers keep their values.
- R7: A short response is 48 bits. Its bits [39:8] go to response word 0, and words 1 to 3 are unchanged.
- R8: A long response is 136 bits. Its bits [127:0] fill words 0 to 3, with word 0 holding bits [127:96].
- R9: Status flags are sticky. Writing address 2 clears each flag whose bit is 1 in the written data and leaves the others set.
- R10: Status bit 8 reads 1 from the start write until the command ends. A control write during that time is ignored.
- R11: After reset the status, response words and prescaler read 0, `cmd_oe` is low, and status bit 12 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| sd_clk | output | 1 | SD bus clock |
| cmd_out | output | 1 | CMD line value driven by the host |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_in | input | 1 | CMD line value from the card |

## Verification
Writes take effect at the `clk` edge that ends the write cycle. The busy bit therefore reads 1 one cycle after the start write, while frame bits appear one SD clock period at a time from the first falling edge after that. The card model in the bench samples `cmd_out` on rising `sd_clk` edges and drives its reply on falling edges, so both sides see a stable line for half an SD period. Status and response words change on the `clk` edge of the final rising SD edge. The bench reads them only after polling shows the busy bit clear, and samples reads half a `clk` period plus a settle delay after the address is applied. The clock period is measured between two rising `sd_clk` edges, taken only after the prescaler write has had a full period to take effect.

// File: rtl/sd_cmd_engine.sv
`timescale 1ns/100ps
module sd_cmd_engine #(
  parameter int PRE_W   = 8,
  parameter int TO_CLKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        sd_clk,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);
  localparam int TO_W       = $clog2(TO_CLKS);
  localparam int FRAME_BITS = 48;
  localparam int SHORT_LAST = 47;
  localparam int LONG_LAST  = 135;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RESP} state_t;

  state_t           st;
  logic [PRE_W-1:0] pre_q, div_cnt;
  logic             sclk_q, cout_q, oe_q;
  logic [31:0]      arg_q;
  logic [5:0]       idx_q;
  logic             host_q, wresp_q, long_q;
  logic             st_fin, st_to, st_sent;
  logic [47:0]      frame_q;
  logic [7:0]       bcnt;
  logic [TO_W-1:0]  to_cnt;
  logic [126:0]     rsh;
  logic [31:0]      resp_q [4];

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  logic         busy, tick, fall_ev, rise_ev, start_wr;
  logic [127:0] nxt;
  logic [7:0]   rlast;

  assign busy     = (st != S_IDLE);
  assign tick     = (div_cnt >= pre_q);
  assign fall_ev  = tick & sclk_q;
  assign rise_ev  = tick & ~sclk_q;
  assign start_wr = wr_en && (wr_addr == 3'd0) && wr_data[8] && !busy;
  assign nxt      = {rsh, cmd_in};
  assign rlast    = long_q ? 8'(LONG_LAST) : 8'(SHORT_LAST);

  assign sd_clk  = sclk_q;
  assign cmd_out = cout_q;
  assign cmd_oe  = oe_q;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {21'b0, long_q, wresp_q, 2'b00, host_q, idx_q};
      3'd1:    rd_data = arg_q;
      3'd2:    rd_data = {19'b0, 1'b0, st_sent, st_to, st_fin, busy, 8'b0};
      3'd3:    rd_data = 32'(pre_q);
      default: rd_data = resp_q[rd_addr[1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pre_q   <= '0;
      div_cnt <= '0;
      sclk_q  <= 1'b0;
      cout_q  <= 1'b1;
      oe_q    <= 1'b0;
      arg_q   <= '0;
      idx_q   <= '0;
      host_q  <= 1'b0;
      wresp_q <= 1'b0;
      long_q  <= 1'b0;
      st_fin  <= 1'b0;
      st_to   <= 1'b0;
      st_sent <= 1'b0;
      frame_q <= '1;
      bcnt    <= '0;
      to_cnt  <= '0;
      rsh     <= '0;
      for (int i = 0; i < 4; i++) resp_q[i] <= '0;
    end else begin
      if (tick) begin
        div_cnt <= '0;
        sclk_q  <= ~sclk_q;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end

      if (wr_en) begin
        case (wr_addr)
          3'd0: if (!busy) begin
            idx_q   <= wr_data[5:0];
            host_q  <= wr_data[6];
            wresp_q <= wr_data[9];
            long_q  <= wr_data[10];
          end
          3'd1: arg_q <= wr_data;
          3'd2: begin
            st_fin  <= st_fin  & ~wr_data[9];
            st_to   <= st_to   & ~wr_data[10];
            st_sent <= st_sent & ~wr_data[11];
          end
          3'd3: pre_q <= wr_data[PRE_W-1:0];
          default: ;
        endcase
      end

      case (st)
        S_IDLE: if (start_wr) begin
          frame_q <= {2'b01, wr_data[5:0], arg_q, crc7({2'b01, wr_data[5:0], arg_q}), 1'b1};
          bcnt    <= '0;
          st      <= S_SEND;
        end
        S_SEND: if (fall_ev) begin
          if (bcnt == 8'(FRAME_BITS)) begin
            oe_q    <= 1'b0;
            cout_q  <= 1'b1;
            st_sent <= 1'b1;
            to_cnt  <= '0;
            st      <= wresp_q ? S_WAIT : S_IDLE;
          end else begin
            oe_q    <= 1'b1;
            cout_q  <= frame_q[47];
            frame_q <= {frame_q[46:0], 1'b1};
            bcnt    <= bcnt + 1'b1;
          end
        end
        S_WAIT: if (rise_ev) begin
          if (!cmd_in) begin
            rsh  <= '0;
            bcnt <= 8'd1;
            st   <= S_RESP;
          end else if (to_cnt == TO_W'(TO_CLKS - 1)) begin
            st_to <= 1'b1;
            st    <= S_IDLE;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        S_RESP: if (rise_ev) begin
          rsh  <= nxt[126:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == rlast) begin
            st_fin <= 1'b1;
            st     <= S_IDLE;
            if (long_q) begin
              resp_q[0] <= nxt[127:96];
              resp_q[1] <= nxt[95:64];
              resp_q[2] <= nxt[63:32];
              resp_q[3] <= nxt[31:0];
            end else begin
              resp_q[0] <= nxt[39:8];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sd_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sd_clk,
  input logic       cmd_out,
  input logic       cmd_oe,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       wr_start,
  input logic       wr_toclr,
  input logic       busy,
  input logic [5:0] idx_q,
  input logic       st_to
);
  p_start_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 3'd0 && wr_start) |=> busy);

  p_release_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_oe);

  p_cmd_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_out) |-> $fell(sd_clk));

  p_w1c_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 3'd2 && wr_toclr) |=> !st_to);

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 3'd0) |=> $stable(idx_q));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_start(wr_data[8]), .wr_toclr(wr_data[10]),
  .busy(busy), .idx_q(idx_q), .st_to(st_to)
);

// File: tb/sd_cmd_engine_test.sv
`timescale 1ns/100ps
module sd_cmd_engine_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmd_in = 1'b1;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire         sd_clk, cmd_out, cmd_oe;
  int          nvec = 0, nerr = 0;
  logic [31:0] rm [4];

  sd_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sd_clk(sd_clk), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [46:0] m;
    m = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
    return m[6:0];
  endfunction

  task automatic card(input int k, input int rlen, input logic [135:0] rv, output logic [47:0] got);
    got = '0;
    do @(posedge sd_clk); while (!cmd_oe);
    got[47] = cmd_out;
    for (int i = 46; i >= 0; i--) begin @(posedge sd_clk); got[i] = cmd_out; end
    if (k > 0) begin
      for (int f = 1; f <= k; f++) @(negedge sd_clk);
      for (int i = rlen - 1; i >= 0; i--) begin
        cmd_in = rv[i];
        if (i > 0) @(negedge sd_clk);
      end
      @(negedge sd_clk); cmd_in = 1'b1;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd2, d);
      if (!d[8]) break;
    end
  endtask

  task automatic do_cmd(input int pre, input logic [5:0] idx, input logic [31:0] arg,
                        input bit wresp, input bit lg, input int k);
    logic [135:0] rv;
    logic [47:0]  got, expf;
    logic [31:0]  d, exps;
    int           rlen;
    bit           ok;
    rlen = lg ? 136 : 48;
    rv = {8'($urandom), $urandom, $urandom, $urandom, $urandom};
    rv[rlen-1] = 1'b0;
    wr(3'd3, 32'(pre));
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd1, arg);
    wr(3'd0, {21'b0, lg, wresp, 1'b1, 1'b0, 1'b1, idx});
    card(wresp ? k : 0, rlen, rv, got);
    wait_idle();
    expf = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    chk("R2 frame hi", got[47:16], expf[47:16]);
    chk("R2 frame lo", 32'(got[15:0]), 32'(expf[15:0]));
    chk("R3 argument", got[39:8], arg);
    chk("R1 index", 32'(got[45:40]), 32'(idx));
    ok = wresp && k >= 1 && k <= 64;
    exps = 32'h800 | (ok ? 32'h200 : 32'h0) | ((wresp && !ok) ? 32'h400 : 32'h0);
    rd(3'd2, d); chk(wresp ? (ok ? "R5 resp done" : "R6 timeout") : "R5 sent only", d, exps);
    if (ok) begin
      if (lg) begin
        rm[0] = rv[127:96]; rm[1] = rv[95:64]; rm[2] = rv[63:32]; rm[3] = rv[31:0];
      end else begin
        rm[0] = rv[39:8];
      end
    end
    for (int w = 0; w < 4; w++) begin
      rd(3'(4 + w), d);
      chk(lg ? "R8 long word" : "R7 short word", d, rm[w]);
    end
  endtask

  task automatic meas(input int pre);
    realtime t1, t2;
    wr(3'd3, 32'(pre));
    @(posedge sd_clk); @(posedge sd_clk); t1 = $realtime;
    @(posedge sd_clk); t2 = $realtime;
    chk("R4 sd_clk period", 32'(int'((t2 - t1) * 10.0)), 32'(2 * (pre + 1) * 50));
  endtask

  initial begin
    #(190000 * 5);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [47:0] got;
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int w = 0; w < 4; w++) rm[w] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd2, d); chk("R11 status reset", d, 32'h0);
    rd(3'd3, d); chk("R11 prescaler reset", d, 32'h0);
    for (int w = 0; w < 4; w++) begin rd(3'(4 + w), d); chk("R11 resp reset", d, 32'h0); end
    chk("R11 cmd_oe reset", 32'(cmd_oe), 32'h0);

    meas(0); meas(3); meas(5);

    do_cmd(1, 6'd0, 32'h0000_0000, 1'b0, 1'b0, 0);
    do_cmd(2, 6'd17, 32'hDEAD_BEEF, 1'b1, 1'b0, 5);
    do_cmd(0, 6'd2, 32'h0, 1'b1, 1'b1, 3);
    do_cmd(1, 6'd13, 32'h0001_0000, 1'b1, 1'b0, 64);
    do_cmd(1, 6'd9, 32'h1234_5678, 1'b1, 1'b1, 65);
    do_cmd(0, 6'd55, 32'hFFFF_FFFF, 1'b1, 1'b0, 0);

    // R9 partial clear after a successful short response
    do_cmd(0, 6'd3, 32'h5A5A_0F0F, 1'b1, 1'b0, 2);
    wr(3'd2, 32'h0000_0800);
    rd(3'd2, d); chk("R9 partial clear", d, 32'h200);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R9 clear all", d, 32'h0);

    // R10 busy flag and ignored control write while busy
    wr(3'd3, 32'd1);
    wr(3'd1, 32'hCAFE_0001);
    wr(3'd0, {21'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd7});
    rd(3'd2, d); chk("R10 busy set", 32'(d[8]), 32'h1);
    wr(3'd0, {21'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd42});
    card(0, 48, '0, got);
    wait_idle();
    chk("R10 index kept", 32'(got[45:40]), 32'd7);
    rd(3'd0, d); chk("R10 control kept", d, 32'h0000_0047);
    rd(3'd2, d); chk("R10 busy clear", d, 32'h800);

    for (int n = 0; n < 24; n++) begin
      int          k;
      logic [5:0]  idx;
      logic [31:0] arg;
      bit          wresp, lg;
      idx   = 6'($urandom);
      arg   = $urandom;
      wresp = 1'($urandom);
      lg    = 1'($urandom);
      k     = 1 + int'($urandom % 70);
      do_cmd(int'($urandom % 3), idx, arg, wresp, lg, k);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule